// File: doc/BRIEF.md
# Oversampled NRZ Bit-Clock Recovery

This block recovers bit timing from an asynchronous NRZ serial line. It uses no analog loop. A local clock running at sixteen times the nominal bit rate (about 111 MHz for a 6.9375 Mbit/s stream) samples the line. The raw level first passes through a two-flop synchroniser. A small history register then screens the synchronised samples. A change of level counts as a real transition only when the two samples before it agree with each other.

Every accepted transition forces a free-running phase counter back to zero. The counter otherwise advances once per clock and wraps after sixteen states. When it reaches its middle state, the block raises a one-cycle strobe and presents the data bit captured on that same edge. Because the phase is realigned on every edge, a local clock that is only roughly right is enough. The strobe stays inside the bit over long runs with no transitions and at input rates several percent away from nominal.

Top module: `nrz_bitclk_recover`

## Requirements
- R1: The `sample_bit` presented with a strobe equals the level of `line_in` at the rising clock edge two edges before the edge that raises the strobe. This delay comes from the two synchroniser stages.
- R2: A transition is accepted only when the synchronised level sampled at edge n differs from the levels sampled at edges n-1 and n-2, and those two earlier levels are equal. A change that comes one edge after another change is not accepted.
- R3: When a transition is accepted from the line level sampled at edge n, the phase counter is zero after edge n+2. The next strobe is therefore high in the cycle after edge n+9.
- R4: While no transition is accepted, the phase counter steps 0..15 and wraps. The strobe is high for exactly one cycle in every sixteen, while the counter holds the value 7.
- R5: While `rst_n` is low at a clock edge, `sample_stb` and `sample_bit` are 0. After release on a steady line, no false transition is seen, and the first strobe follows the 7th edge after release.
- R6: `sample_bit` changes only on the edge that raises `sample_stb`, and it holds its value between strobes.
- R7: At the nominal period of 16 clocks, each bit of a pattern is sampled exactly once with the correct value. This includes runs of 14 identical bits.
- R8: At bit periods of 15 clocks (about 6.7% fast) and 17 clocks (about 6% slow), each bit of an alternating pattern is sampled exactly once with the correct value.
- R9: A one-clock pulse on a steady line realigns the phase at its leading edge only. The first strobe after it follows edge n+9, where n is the edge that sampled the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 16 times the nominal bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Raw asynchronous NRZ serial line |
| sample_stb | output | 1 | One-cycle strobe near the middle of each bit |
| sample_bit | output | 1 | Recovered data bit, valid while the strobe is high and held until the next strobe |

## Verification
Realignment and the counter's own wrap, or realignment and the strobe, can fall in the same cycle. In that cycle the accepted edge must win, or the sample point slips by a bit. The off-rate runs provoke this. At 15 clocks per bit, edges arrive while the counter is near its top. At 17 clocks per bit, they arrive just after it has wrapped. The glitch cases place a transition into an idle counter that would otherwise strobe soon after. Each strobe edge and each captured bit is judged against a bench-side prediction. That prediction comes only from the latencies and the acceptance rule stated in R1 to R4.

// File: rtl/nrzr_pkg.sv
// Package: shared defaults for the NRZ bit-clock recovery block.
// Assumes: oversampling is a power of two, and history and synchroniser depths are at least 2.
package nrzr_pkg;
    localparam int OVERSAMPLE_DEF  = 16;
    localparam int SYNC_STAGES_DEF = 2;
    localparam int HIST_DEPTH_DEF  = 2;
endpackage

// File: rtl/nrzr_sync.sv
// Module: multi-flop synchroniser bringing the raw line into the sampling clock domain.
// Assumes: STAGES >= 2. Reset preloads every stage with the present line level,
// so that leaving reset shows no spurious change.
module nrzr_sync #(
    parameter int STAGES = nrzr_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    // Shift the line level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= {STAGES{din}};
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/nrzr_edge_filter.sv
// Module: glitch-screening transition detector.
// It flags a transition when every entry of the sample history agrees and the
// current synchronised sample differs from them.
// Assumes: DEPTH >= 2. Reset loads the history with the current sample.
module nrzr_edge_filter #(
    parameter int DEPTH = nrzr_pkg::HIST_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cur_i,
    output logic edge_o
);
    logic [DEPTH-1:0] hist_q;   // hist_q[0] is the most recent past sample

    // Keep the last DEPTH synchronised samples.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_hist
            always_ff @(posedge clk) begin
                if (!rst_n)      hist_q[g] <= cur_i;
                else if (g == 0) hist_q[g] <= cur_i;
                else             hist_q[g] <= hist_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Accept only a change that follows a settled history.
    always_comb begin
        edge_o = (hist_q == {DEPTH{hist_q[0]}}) && (cur_i != hist_q[0]);
    end

    // R2: a change immediately after an accepted one is never accepted.
    assert_no_back2back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/nrzr_phase_ctr.sv
// Module: phase counter, mid-bit strobe and data capture.
// It realigns to zero on an accepted edge, otherwise advances and wraps.
// The strobe and the data bit are registered on the same edge.
// Assumes: OVERSAMPLE >= 4, and edge_i comes straight from the filter.
module nrzr_phase_ctr #(
    parameter int OVERSAMPLE = nrzr_pkg::OVERSAMPLE_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic data_i,
    output logic stb_o,
    output logic bit_o
);
    localparam int W = $clog2(OVERSAMPLE);
    localparam logic [W-1:0] LAST = W'(OVERSAMPLE - 1);
    localparam logic [W-1:0] MID  = W'(OVERSAMPLE / 2 - 1);

    logic [W-1:0] cnt_q, cnt_nxt;
    logic         stb_q, bit_q;

    // Next phase: realignment has priority over advancing and wrapping.
    always_comb begin
        if (edge_i)              cnt_nxt = '0;
        else if (cnt_q == LAST)  cnt_nxt = '0;
        else                     cnt_nxt = cnt_q + W'(1);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // Strobe while the phase sits at mid-bit, and capture the bit with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            bit_q <= 1'b0;
        end else begin
            stb_q <= (cnt_nxt == MID);
            if (cnt_nxt == MID) bit_q <= data_i;
        end
    end

    assign stb_o = stb_q;
    assign bit_o = bit_q;

    // R3: an accepted edge zeroes the phase on the next clock edge.
    assert_realign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> (cnt_q == '0));
    // R4: phase advances by one when there is no edge and no wrap.
    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + W'(1)));
    // R4: phase wraps from the top state to zero.
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && cnt_q == LAST) |=> (cnt_q == '0));
    // R4: the strobe is only ever seen at the mid phase.
    assert_strobe_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> (cnt_q == MID));
    // R6: the data bit moves only together with a strobe.
    assert_bit_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_q) |-> stb_q);
endmodule

// File: rtl/nrz_bitclk_recover.sv
// Module: top of the oversampled NRZ bit-clock recovery block.
// Chain: synchroniser, then edge filter, then phase counter with strobe.
// Assumes: clk runs at OVERSAMPLE times the nominal bit rate, and rst_n is synchronous and active low.
module nrz_bitclk_recover #(
    parameter int OVERSAMPLE  = nrzr_pkg::OVERSAMPLE_DEF,
    parameter int SYNC_STAGES = nrzr_pkg::SYNC_STAGES_DEF,
    parameter int HIST_DEPTH  = nrzr_pkg::HIST_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic sample_stb,
    output logic sample_bit
);
    logic line_sync;
    logic edge_ok;

    nrzr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .dout (line_sync)
    );

    nrzr_edge_filter #(.DEPTH(HIST_DEPTH)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .cur_i (line_sync),
        .edge_o(edge_ok)
    );

    nrzr_phase_ctr #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .edge_i(edge_ok),
        .data_i(line_sync),
        .stb_o (sample_stb),
        .bit_o (sample_bit)
    );
endmodule

// File: tb/nrz_bitclk_recover_test.sv
// Directed bench for nrz_bitclk_recover. A monitor predicts the strobe and bit
// from the stated latencies (R1..R4). Each task checks its own scenario.
module nrz_bitclk_recover_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b1;
    logic sample_stb, sample_bit;

    int    n_vec = 0, n_bad = 0;
    int    ecount = 0;          // rising edges since reset release
    int    keff = -2;           // edge of the last accepted transition in effect
    bit    line_at [0:8191];    // line level per edge, offset by 4
    bit    exp_stb = 1'b0, exp_bit = 1'b0;
    int    stb_cnt = 0;
    string tag = "R5";
    bit    done = 1'b0;

    nrz_bitclk_recover uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .sample_stb(sample_stb), .sample_bit(sample_bit)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string r, input string what, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", r, what, act, expv, ecount);
        end
    endtask

    function automatic bit accepted(input int k);   // R2 acceptance rule
        return (line_at[k+4] != line_at[k+3]) && (line_at[k+3] == line_at[k+2]);
    endfunction

    // Bookkeeping at each rising edge: the prediction from R1..R4.
    always @(posedge clk) begin
        if (!rst_n) begin
            ecount = 0; keff = -2; exp_bit = 1'b0; exp_stb = 1'b0;
            for (int i = 0; i < 5; i++) line_at[i] = line_in;
        end else begin
            ecount++;
            if (ecount + 4 < 8192) line_at[ecount+4] = line_in;
            if (ecount >= 3 && accepted(ecount - 2)) keff = ecount - 2;
            exp_stb = (ecount - keff >= 9) && (((ecount - keff - 9) % 16) == 0);
            if (exp_stb) exp_bit = line_at[ecount + 2];   // level at edge ecount-2 (R1)
        end
    end

    // Compare the outputs at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sample_stb == exp_stb, {"R3,R4,", tag}, "strobe", sample_stb, exp_stb);
            // R1 value, R6 hold between strobes
            chk(sample_bit == exp_bit, {"R1,R6,", tag}, "bit", sample_bit, exp_bit);
            if (sample_stb) stb_cnt++;
        end
    end

    task automatic do_reset(input bit lvl);
        @(negedge clk); #1;
        rst_n = 1'b0; line_in = lvl;
        repeat (3) begin
            @(negedge clk);
            chk(sample_stb == 1'b0, "R5", "strobe in reset", sample_stb, 0);
            chk(sample_bit == 1'b0, "R5", "bit in reset", sample_bit, 0);
        end
        #1 rst_n = 1'b1;
    endtask

    // Drive n bits of per clocks each, and count strobes from bit 0 onward.
    task automatic run_bits(input bit pat [64], input int n, input int per, input string r);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1 line_in = pat[i];
            if (i == 0) begin
                @(negedge clk); @(negedge clk); #1 stb_cnt = 0;
                repeat (per - 3) @(negedge clk);
            end else begin
                repeat (per - 1) @(negedge clk);
            end
        end
        @(negedge clk); #2;
        chk(stb_cnt == n, r, "strobes per bit run", stb_cnt, n);
    endtask

    task automatic t_reset_idle;   // R5
        tag = "R5";
        do_reset(1'b1);
        while (ecount < 6) @(negedge clk);
        chk(sample_stb == 1'b0, "R5", "no strobe at edge 6", sample_stb, 0);
        @(negedge clk);
        chk(sample_stb == 1'b1, "R5", "first strobe at edge 7", sample_stb, 1);
        chk(sample_bit == 1'b1, "R5", "idle bit", sample_bit, 1);
        @(negedge clk);
        chk(sample_stb == 1'b0, "R5", "strobe one cycle wide", sample_stb, 0);
    endtask

    task automatic t_nominal;      // R7: runs of 14 at 16 clocks per bit
        bit pat [64];
        int n = 0;
        tag = "R7";
        do_reset(1'b0);
        repeat (20) @(negedge clk);
        pat[n++] = 1'b1; pat[n++] = 1'b0;
        for (int i = 0; i < 14; i++) pat[n++] = 1'b1;
        for (int i = 0; i < 14; i++) pat[n++] = 1'b0;
        pat[n++] = 1'b1; pat[n++] = 1'b0; pat[n++] = 1'b0; pat[n++] = 1'b1;
        run_bits(pat, n, 16, "R7");
    endtask

    task automatic t_offrate;      // R8: 17 and 15 clocks per bit
        bit pat [64];
        tag = "R8";
        do_reset(1'b1);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 40; i++) pat[i] = i[0];
        run_bits(pat, 40, 17, "R8 slow");
        run_bits(pat, 40, 15, "R8 fast");
    endtask

    task automatic t_glitch;       // R9 and R2
        int k;
        tag = "R9";
        do_reset(1'b1);
        while (ecount < 40) @(negedge clk);
        #1 line_in = 1'b0; k = ecount + 1;
        @(negedge clk); #1 line_in = 1'b1;
        while (!(sample_stb && ecount >= k + 2) && ecount < k + 40) @(negedge clk);
        chk(ecount == k + 9, "R9", "strobe edge after one-clock pulse", ecount, k + 9);
        tag = "R2";
        while (ecount < 100) @(negedge clk);
        #1 line_in = 1'b0; k = ecount + 1;
        @(negedge clk); @(negedge clk); #1 line_in = 1'b1;
        while (!(sample_stb && ecount >= k + 4) && ecount < k + 40) @(negedge clk);
        chk(ecount == k + 11, "R2", "strobe edge after two-clock pulse", ecount, k + 11);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        t_reset_idle();
        t_nominal();
        t_offrate();
        t_glitch();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule